// File: doc/BRIEF.md
# Modem Control Change Scanner

This block is the modem-control part of a sixteen-channel terminal multiplexer. Each channel keeps six control bits written by the host: two outputs driven to the modem (request-to-send and data-terminal-ready), two compare-enable bits and two reference bits. It also samples two status inputs per channel from the modem (carrier detect and data-set-ready). A channel "has changed" when an enabled status bit differs from its reference bit.

The host reaches the block through one control-write port and one status-read port. A control write can rewrite one channel's register, and it always switches automatic scanning on or off. A status read returns the channel under the channel pointer and moves the pointer on by one. While scanning is on and the attention flag is low, the block walks the pointer one channel per clock, for at most one full lap. It stops and raises the flag at the first channel that has changed. The host lowers the flag with a clear strobe.

For a line in data-set mode, dropping its data-terminal-ready output hangs the line up. The block emits a one-cycle line-reset pulse and holds that channel's sampled status at zero until data-terminal-ready is raised again.

Top module: `mdm_chg_scanner`

## Requirements
- R1: After reset the flag is 1, the channel pointer is 0, scanning is off, and every channel's control, reference, enable and status bits are 0. A read then returns 16'hC000 and all rts/dtr outputs are 0.
- R2: Every control write loads the scan-enable state from write bit 15, whether or not the update bit (bit 14) is set. While scanning is off, the pointer moves only on reads.
- R3: A control write with bit 14 set addresses channel bits 13:10 and always overwrites that channel's enables from bits 3:2 (ES2, ES1) and its references from bits 1:0 (SS2, SS1). Bit 5 is loaded into rts only when bit 7 is set. Bit 4 is loaded into dtr only when bit 6 is set.
- R4: A channel's change indicator pair is (S xor SS) and ES, taken bitwise over the pairs {S2,S1}, {SS2,SS1} and {ES2,ES1}.
- R5: Read data is laid out as follows: bits 15:14 read 1, bits 13:10 hold the pointer channel, bits 9:8 hold the indicators I2/I1, bits 3:2 hold ES2/ES1, bits 1:0 hold S2/S1, and bits 7:4 read 0.
- R6: Each read strobe advances the pointer by one, so channel 15 is followed by channel 0.
- R7: While scanning is on and the flag is 0, the pointer steps once per clock. At the first step that lands on a channel with a nonzero indicator, the flag is set and the pointer stays on that channel.
- R8: A scan makes at most 16 steps. If no channel has changed, the flag stays 0 and the pointer comes to rest where the scan began.
- R9: While the flag is 1, the scanner does not move the pointer, and the flag stays 1 until it is cleared.
- R10: When dataset_mode is set for a channel, a write that takes its dtr from 1 to 0 produces a one-cycle line_reset pulse for that channel. It also forces the channel's sampled status to 0 until dtr is written back to 1. With dataset_mode clear, the same write does neither.
- R11: clr_flag lowers the flag, and it, like any control write, grants the scanner a fresh budget of 16 steps.
- R12: Status input line_sts[2k+1] (S2) and line_sts[2k] (S1) of channel k appear in the read data and indicators one clock after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 16 | Control write word |
| rd_en | input | 1 | Status read strobe; advances the pointer |
| rd_data | output | 16 | Status word of the pointer channel |
| clr_flag | input | 1 | Lowers the attention flag |
| flag | output | 1 | Attention flag |
| line_sts | input | 2*N_CH | Live modem status, {S2,S1} per channel |
| dataset_mode | input | N_CH | Per-line data-set (hangup) mode |
| rts | output | N_CH | Request-to-send outputs (C2) |
| dtr | output | N_CH | Data-terminal-ready outputs (C1) |
| line_reset | output | N_CH | One-cycle hangup pulse per line |

## Verification
The check that a flag rise lands on a changed channel assumes that line_sts has been steady for the two cycles before the rise and that no control write came in the cycle before it. Without those conditions the indicator could move between the step decision and the read. The bench changes modem status only while scanning is off or the flag is high, and it then waits out the sampling latency before it enables a scan or clears the flag. The hangup checks assume that only a write that clears data-terminal-ready can produce a pulse. The bench therefore drives line_reset stimulus only through control writes.

// File: rtl/mdm_scan_pkg.sv
package mdm_scan_pkg;

  localparam int WORD_W   = 16;
  localparam int CHF_W    = 4;   // channel field width in host words
  localparam int CHF_LSB  = 10;
  localparam int B_SCAN   = 15;
  localparam int B_UPD    = 14;
  localparam int B_EC2    = 7;
  localparam int B_EC1    = 6;
  localparam int B_C2     = 5;
  localparam int B_C1     = 4;
  localparam int B_ES2    = 3;
  localparam int B_ES1    = 2;
  localparam int B_SS2    = 1;
  localparam int B_SS1    = 0;

  typedef struct packed {
    logic c2;
    logic c1;
    logic es2;
    logic es1;
    logic ss2;
    logic ss1;
  } ch_ctl_t;

  typedef struct packed {
    logic             scan;
    logic             upd;
    logic [CHF_W-1:0] ch;
    logic             ec2;
    logic             ec1;
    logic             c2;
    logic             c1;
    logic             es2;
    logic             es1;
    logic             ss2;
    logic             ss1;
  } ctl_wr_t;

  function automatic ctl_wr_t decode_wr(input logic [WORD_W-1:0] w);
    ctl_wr_t d;
    d.scan = w[B_SCAN];
    d.upd  = w[B_UPD];
    d.ch   = w[CHF_LSB +: CHF_W];
    d.ec2  = w[B_EC2];
    d.ec1  = w[B_EC1];
    d.c2   = w[B_C2];
    d.c1   = w[B_C1];
    d.es2  = w[B_ES2];
    d.es1  = w[B_ES1];
    d.ss2  = w[B_SS2];
    d.ss1  = w[B_SS1];
    return d;
  endfunction

  function automatic ch_ctl_t merge_ctl(input ch_ctl_t cur, input ctl_wr_t w);
    ch_ctl_t n;
    n.es2 = w.es2;
    n.es1 = w.es1;
    n.ss2 = w.ss2;
    n.ss1 = w.ss1;
    n.c2  = w.ec2 ? w.c2 : cur.c2;
    n.c1  = w.ec1 ? w.c1 : cur.c1;
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic [CHF_W-1:0] ch,
                                                    input logic [1:0] ind,
                                                    input logic [1:0] es,
                                                    input logic [1:0] s);
    logic [WORD_W-1:0] r;
    r = '0;
    r[15:14] = 2'b11;
    r[CHF_LSB +: CHF_W] = ch;
    r[9:8] = ind;
    r[3:2] = es;
    r[1:0] = s;
    return r;
  endfunction

endpackage

// File: rtl/mdm_chan_bank.sv
module mdm_chan_bank
  import mdm_scan_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_en,
  input  ctl_wr_t                   upd_word,
  input  logic [2*N_CH-1:0]         line_sts,
  input  logic [N_CH-1:0]           dataset_mode,
  output ch_ctl_t [N_CH-1:0]        ctl_q,
  output logic [N_CH-1:0][1:0]      stat_q,
  output logic [N_CH-1:0][1:0]      ind,
  output logic [N_CH-1:0]           line_reset
);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic    sel;
    ch_ctl_t nxt;
    logic    hup;
    logic    dtr_up;
    logic    hold_q;
    logic    lrst_q;

    assign sel    = upd_en && (upd_word.ch == CHF_W'(i));
    assign nxt    = merge_ctl(ctl_q[i], upd_word);
    assign hup    = sel && dataset_mode[i] && ctl_q[i].c1 && !nxt.c1;
    assign dtr_up = sel && !ctl_q[i].c1 && nxt.c1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[i]  <= '0;
        stat_q[i] <= '0;
        hold_q    <= 1'b0;
        lrst_q    <= 1'b0;
      end else begin
        if (sel) ctl_q[i] <= nxt;
        if (hup)         hold_q <= 1'b1;
        else if (dtr_up) hold_q <= 1'b0;
        stat_q[i] <= (hup || hold_q) ? 2'b00 : line_sts[2*i +: 2];
        lrst_q    <= hup;
      end
    end

    assign ind[i] = (stat_q[i] ^ {ctl_q[i].ss2, ctl_q[i].ss1})
                    & {ctl_q[i].es2, ctl_q[i].es1};
    assign line_reset[i] = lrst_q;
  end

endmodule

// File: rtl/mdm_scan_ctrl.sv
module mdm_scan_ctrl #(
  parameter int N_CH = 16,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int ST_W = $clog2(N_CH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_scan,
  input  logic            rd_en,
  input  logic            clr_flag,
  input  logic [N_CH-1:0] chg_any,
  output logic [CH_W-1:0] ptr,
  output logic            flag,
  output logic            scan_on
);

  logic [CH_W-1:0] nxt;
  logic [ST_W-1:0] steps;
  logic            budget_left;

  assign nxt         = (ptr == CH_W'(N_CH - 1)) ? '0 : ptr + CH_W'(1);
  assign budget_left = (steps != ST_W'(N_CH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      flag    <= 1'b1;
      scan_on <= 1'b0;
      steps   <= '0;
    end else begin
      if (wr_en) scan_on <= wr_scan;
      if (rd_en) begin
        ptr <= nxt;
      end else if (scan_on && !flag && budget_left) begin
        ptr   <= nxt;
        steps <= steps + ST_W'(1);
        if (chg_any[nxt]) flag <= 1'b1;
      end
      if (wr_en || clr_flag) steps <= '0;
      if (clr_flag) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/mdm_status_view.sv
module mdm_status_view
  import mdm_scan_pkg::*;
#(
  parameter int N_CH = 16,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [CH_W-1:0]        ptr,
  input  ch_ctl_t [N_CH-1:0]     ctl_q,
  input  logic [N_CH-1:0][1:0]   stat_q,
  input  logic [N_CH-1:0][1:0]   ind,
  output logic [WORD_W-1:0]      rd_data
);

  ch_ctl_t cur;

  always_comb begin
    cur     = ctl_q[ptr];
    rd_data = pack_status(CHF_W'(ptr), ind[ptr], {cur.es2, cur.es1}, stat_q[ptr]);
  end

endmodule

// File: rtl/mdm_chg_scanner.sv
module mdm_chg_scanner
  import mdm_scan_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  output logic [15:0]       rd_data,
  input  logic              clr_flag,
  output logic              flag,
  input  logic [2*N_CH-1:0] line_sts,
  input  logic [N_CH-1:0]   dataset_mode,
  output logic [N_CH-1:0]   rts,
  output logic [N_CH-1:0]   dtr,
  output logic [N_CH-1:0]   line_reset
);

  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  ctl_wr_t               wr_dec;
  ch_ctl_t [N_CH-1:0]    ctl_q;
  logic [N_CH-1:0][1:0]  stat_q;
  logic [N_CH-1:0][1:0]  ind;
  logic [N_CH-1:0]       chg_any;
  logic [CH_W-1:0]       ptr;
  logic                  scan_on;

  assign wr_dec = decode_wr(wr_data);

  mdm_chan_bank #(.N_CH(N_CH)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_en       (wr_en && wr_dec.upd),
    .upd_word     (wr_dec),
    .line_sts     (line_sts),
    .dataset_mode (dataset_mode),
    .ctl_q        (ctl_q),
    .stat_q       (stat_q),
    .ind          (ind),
    .line_reset   (line_reset)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_out
    assign rts[i]     = ctl_q[i].c2;
    assign dtr[i]     = ctl_q[i].c1;
    assign chg_any[i] = |ind[i];
  end

  mdm_scan_ctrl #(.N_CH(N_CH)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_scan  (wr_dec.scan),
    .rd_en    (rd_en),
    .clr_flag (clr_flag),
    .chg_any  (chg_any),
    .ptr      (ptr),
    .flag     (flag),
    .scan_on  (scan_on)
  );

  mdm_status_view #(.N_CH(N_CH)) u_view (
    .ptr     (ptr),
    .ctl_q   (ctl_q),
    .stat_q  (stat_q),
    .ind     (ind),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/mdm_chg_scanner_chk.sv
module mdm_chg_scanner_chk #(
  parameter int N_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [15:0]       wr_data,
  input logic              rd_en,
  input logic [15:0]       rd_data,
  input logic              clr_flag,
  input logic              flag,
  input logic [2*N_CH-1:0] line_sts,
  input logic [N_CH-1:0]   dtr,
  input logic [N_CH-1:0]   rts,
  input logic [N_CH-1:0]   line_reset,
  input logic              scan_on
);

  logic [3:0] ch_after;
  assign ch_after = (rd_data[13:10] == 4'(N_CH - 1)) ? 4'd0 : rd_data[13:10] + 4'd1;

  AST_RD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:14] == 2'b11 && rd_data[7:4] == 4'b0000); // R5

  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data[13:10] == $past(ch_after)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_flag |=> flag); // R9

  AST_FLAG_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !rd_en |=> $stable(rd_data[13:10])); // R9

  AST_SCAN_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_on && !rd_en |=> $stable(rd_data[13:10])); // R2

  AST_DTR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[14] && wr_data[6]) |=> $stable(dtr)); // R3

  AST_RTS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[14] && wr_data[7]) |=> $stable(rts)); // R3

  AST_HANGUP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    |line_reset |-> $past(wr_en && wr_data[14] && wr_data[6] && !wr_data[4])); // R10

  AST_HANGUP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_reset)); // R10

  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) && $past(!wr_en) && $stable(line_sts) && $past($stable(line_sts))
    |-> rd_data[9:8] != 2'b00); // R7

endmodule

bind mdm_chg_scanner mdm_chg_scanner_chk #(.N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .clr_flag   (clr_flag),
  .flag       (flag),
  .line_sts   (line_sts),
  .dtr        (dtr),
  .rts        (rts),
  .line_reset (line_reset),
  .scan_on    (scan_on)
);

// File: tb/mdm_chg_scanner_test.sv
module mdm_chg_scanner_test;

  localparam int N = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [15:0]       wr_data = '0;
  logic              rd_en = 1'b0;
  logic [15:0]       rd_data;
  logic              clr_flag = 1'b0;
  logic              flag;
  logic [2*N-1:0]    line_sts = '0;
  logic [N-1:0]      dataset_mode = '0;
  logic [N-1:0]      rts, dtr, line_reset;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mdm_chg_scanner #(.N_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .clr_flag(clr_flag), .flag(flag),
    .line_sts(line_sts), .dataset_mode(dataset_mode),
    .rts(rts), .dtr(dtr), .line_reset(line_reset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_step();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic goto_ch(input int k);
    for (int i = 0; i < N && rd_data[13:10] != 4'(k); i++) rd_step();
  endtask

  task automatic clr();
    @(negedge clk);
    clr_flag = 1'b1;
    @(negedge clk);
    clr_flag = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flag", 32'(flag), 1);
    chk("R1 read", 32'(rd_data), 32'hC000);
    chk("R1 rts", 32'(rts), 0);
    chk("R1 dtr", 32'(dtr), 0);
  endtask

  task automatic t_update();
    wr(16'h4CBD); // ch3 EC2 C2 C1(no EC1) ES=11 SS=01
    chk("R3 rts set by EC2", 32'(rts), 32'h0008);
    chk("R3 dtr held without EC1", 32'(dtr), 0);
    wr(16'h4C5D); // ch3 EC1 C1, no EC2, C2=0
    chk("R3 rts kept without EC2", 32'(rts), 32'h0008);
    chk("R3 dtr set by EC1", 32'(dtr), 32'h0008);
  endtask

  task automatic t_layout();
    line_sts[7:6] = 2'b10;
    cyc(1);
    goto_ch(3);
    chk("R4 R5 R12 ind 11", 32'(rd_data), 32'hCF0E);
    wr(16'h4C5E); // ES=11 SS=10
    chk("R4 ind 00 matched ref", 32'(rd_data), 32'hCC0E);
    wr(16'h4C54); // ES=01 SS=00
    chk("R4 ind masked by ES", 32'(rd_data), 32'hCC06);
  endtask

  task automatic t_wrap();
    goto_ch(15);
    chk("R6 at 15", 32'(rd_data[13:10]), 15);
    rd_step();
    chk("R6 wrap to 0", 32'(rd_data[13:10]), 0);
  endtask

  task automatic t_scan_off();
    wr(16'h4C5D); // ch3 changed again, scan off
    clr();
    cyc(20);
    chk("R2 no scan while off", 32'(rd_data[13:10]), 0);
    chk("R11 flag cleared", 32'(flag), 0);
  endtask

  task automatic t_scan_find();
    wr(16'h8000); // scan on, no update
    cyc(10);
    chk("R2 R7 flag set", 32'(flag), 1);
    chk("R7 stopped on ch3", 32'(rd_data[13:10]), 3);
    cyc(10);
    chk("R9 parked on ch3", 32'(rd_data[13:10]), 3);
  endtask

  task automatic t_budget();
    wr(16'hCC00); // ch3 ES=00, scan on
    clr();
    cyc(40);
    chk("R8 no flag after lap", 32'(flag), 0);
    chk("R8 rest at start", 32'(rd_data[13:10]), 3);
    line_sts[10] = 1'b1;
    cyc(2);
    chk("R8 idle after budget", 32'(rd_data[13:10]), 3);
    wr(16'hD404); // ch5 ES1, scan on: fresh budget
    cyc(10);
    chk("R11 write renews budget flag", 32'(flag), 1);
    chk("R11 write renews budget ch", 32'(rd_data[13:10]), 5);
    clr();
    cyc(3);
    chk("R11 clear restarts scan", 32'(flag), 0);
    cyc(30);
    chk("R11 full lap back to ch5", 32'(rd_data[13:10]), 5);
    chk("R7 flag after lap", 32'(flag), 1);
  endtask

  task automatic t_hangup();
    dataset_mode[7] = 1'b1;
    wr(16'h5C50); // ch7 EC1 C1, scan off
    line_sts[15:14] = 2'b11;
    cyc(2);
    goto_ch(7);
    chk("R12 ch7 status", 32'(rd_data), 32'hDC03);
    wr(16'h5C40); // drop dtr
    chk("R10 pulse", 32'(line_reset), 32'h0080);
    chk("R10 dtr low", 32'(dtr[7]), 0);
    cyc(3);
    chk("R10 pulse one cycle", 32'(line_reset), 0);
    chk("R10 status held clear", 32'(rd_data), 32'hDC00);
    wr(16'h5C50);
    cyc(1);
    chk("R10 status back after dtr", 32'(rd_data), 32'hDC03);
    wr(16'h6050); // ch8 dtr on, no dataset mode
    line_sts[17:16] = 2'b11;
    cyc(2);
    wr(16'h6040);
    chk("R10 no pulse without mode", 32'(line_reset), 0);
    goto_ch(8);
    chk("R10 status kept without mode", 32'(rd_data), 32'hE003);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_update();
    t_layout();
    t_wrap();
    t_scan_off();
    t_scan_find();
    t_budget();
    t_hangup();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule